// File: doc/BRIEF.md
# System-Control Register Write Bank

This block holds the privileged control registers of a small 32-bit core: TLB staging registers, status and cause, exception return addresses, watch, cache tag and debug state. A single write strobe carries a select code and a 32-bit value. Each register merges that value through its own mask: bits the software may set are taken from the write, some fields keep their earlier contents, and every other bit stays zero. A separate select code reads any register combinationally.

Besides the register contents, the bank drives four mode flags (user, exception level, error level, debug), a one-cycle pulse that tells the TLB to flush when the address-space identifier changes, and a level-sensitive hardware interrupt request. The request is re-evaluated only by writes to the status register. Hardware interrupt-pending lines arrive on a side input and show up in the cause register's read value.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset every register reads zero, all four mode flags are low, the interrupt request is low and the flush pulse is low.
- R2: Select 0 (index) takes bits 3:0 from a write, keeps bit 31 and reads zero elsewhere.
- R3: Selects 1 and 2 (two TLB entry-low words) store the write ANDed with 0x3FFFFFFF, select 5 (wired count) keeps bits 3:0, select 4 (page mask) keeps bits 24:13.
- R4: Select 3 (page-table context) takes bits 22:4 from a write, keeps bits 31:23 and reads zero in bits 3:0.
- R5: Select 6 (entry-high) stores the write ANDed with 0xFFFFE0FF; when bits 7:0 of the write differ from the stored bits 7:0, tlb_flush_o is high for exactly the one cycle after the write edge, and it stays low otherwise.
- R6: Select 7 (status) stores the write ANDed with 0xFA78FF01; mode_um_o, mode_erl_o and mode_exl_o take bits 4, 2 and 1 of the written value.
- R7: A status write raises irq_o only when its bit 0 (interrupt enable) is 1 while the stored bit 0 was 0, its bits 1 and 2 are both 0, mode_dm_o is low, and bits 15:8 of the write AND bits 15:8 of the cause read value are nonzero.
- R8: A status write with bit 0 at 0 while the stored bit 0 was 1 lowers irq_o; every other write leaves irq_o unchanged.
- R9: Select 8 (cause) takes only bits 23:22 and 9:8 from a write and keeps all other stored bits; its read value shows hw_pend_i in bits 15:10.
- R10: Select 12 (debug) takes only the bits in 0x13300120 from a write and keeps those in 0x8C03FC1F; mode_dm_o takes bit 30 of the written value.
- R11: Selects 9, 10, 13, 15 and 16 store all 32 bits; select 11 keeps the bits in 0x40FF0FF8 and select 14 the bits in 0xFFFFFCF6.
- R12: A write to a select code from 17 to 31 changes no register, flag, request or pulse, and those codes read zero.
- R13: A write becomes visible in the read value, flags and request on the clock edge that samples the strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 5 | Register select for the write |
| wr_data_i | input | 32 | Write value |
| rd_sel_i | input | 5 | Register select for the read |
| rd_data_o | output | 32 | Combinational read value |
| hw_pend_i | input | 6 | Hardware interrupt-pending lines, seen in cause bits 15:10 |
| mode_um_o | output | 1 | User-mode flag |
| mode_exl_o | output | 1 | Exception-level flag |
| mode_erl_o | output | 1 | Error-level flag |
| mode_dm_o | output | 1 | Debug-mode flag |
| irq_o | output | 1 | Hardware interrupt request level |
| tlb_flush_o | output | 1 | One-cycle TLB flush pulse |

## Verification
The assertions assume a single write strobe that names one select per cycle, so status and debug updates never collide, and that hw_pend_i is a plain level the bank only reads. The bench drives every input on the falling edge and holds hw_pend_i constant across each write, so the cause value the request logic sees is the one the bench model used. A sweep writes several bit patterns to all 32 select codes and reads back every code after each write, and directed status sequences walk the request through each blocking condition.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN   = 32;
    localparam int SEL_W  = 5;
    localparam int NREG   = 17;
    localparam int HWP_W  = 6;
    localparam int ASID_W = 8;

    // status / debug bit positions the flag logic decodes
    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_UM  = 4;
    localparam int IM_LO  = 8;
    localparam int IM_W   = 8;
    localparam int HWP_LO = 10;
    localparam int DB_DM  = 30;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDX    = 5'd0,
        SEL_ELO0   = 5'd1,
        SEL_ELO1   = 5'd2,
        SEL_CTX    = 5'd3,
        SEL_PGMSK  = 5'd4,
        SEL_WIRED  = 5'd5,
        SEL_EHI    = 5'd6,
        SEL_STAT   = 5'd7,
        SEL_CAUSE  = 5'd8,
        SEL_EPC    = 5'd9,
        SEL_WLO    = 5'd10,
        SEL_WHI    = 5'd11,
        SEL_DBG    = 5'd12,
        SEL_DEPC   = 5'd13,
        SEL_TAGLO  = 5'd14,
        SEL_ERREPC = 5'd15,
        SEL_DSAVE  = 5'd16
    } sel_e;

    typedef struct packed {
        logic um;
        logic exl;
        logic erl;
        logic dm;
    } mode_t;

    // bits a write may set
    function automatic word_t wr_mask(int unsigned idx);
        case (idx)
            0:              return 32'h0000_000F;
            1, 2:           return 32'h3FFF_FFFF;
            3:              return 32'h007F_FFF0;
            4:              return 32'h01FF_E000;
            5:              return 32'h0000_000F;
            6:              return 32'hFFFF_E0FF;
            7:              return 32'hFA78_FF01;
            8:              return 32'h00C0_0300;
            11:             return 32'h40FF_0FF8;
            12:             return 32'h1330_0120;
            14:             return 32'hFFFF_FCF6;
            9, 10, 13, 15, 16: return 32'hFFFF_FFFF;
            default:        return 32'h0;
        endcase
    endfunction

    // bits that survive a write
    function automatic word_t keep_mask(int unsigned idx);
        case (idx)
            0:       return 32'h8000_0000;
            3:       return 32'hFF80_0000;
            8:       return ~32'h00C0_0300;
            12:      return 32'h8C03_FC1F;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_cell.sv
module sysctl_cell
    import sysctl_pkg::*;
#(
    parameter word_t KEEP  = '0,
    parameter word_t WMASK = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t wd,
    output word_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= (q & KEEP) | (wd & WMASK);
    end

    // R13: contents only move on a write edge
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R4: preserved fields survive a write
    a_r4_keep_bits: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & KEEP) == ($past(q) & KEEP)));

endmodule

// File: rtl/sysctl_mode_irq.sv
module sysctl_mode_irq
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stat_we,
    input  logic            dbg_we,
    input  logic            wd_ie,
    input  logic            wd_exl,
    input  logic            wd_erl,
    input  logic            wd_um,
    input  logic            wd_dm,
    input  logic [IM_W-1:0] wd_im,
    input  logic            old_ie,
    input  logic [IM_W-1:0] cause_ip,
    output mode_t           mode,
    output logic            irq
);

    logic pend, raise, drop;

    always_comb begin
        pend  = |(wd_im & cause_ip);
        raise = stat_we && wd_ie && !old_ie && !wd_exl && !wd_erl
                && !mode.dm && pend;
        drop  = stat_we && !wd_ie && old_ie;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            irq  <= 1'b0;
        end else begin
            if (stat_we) begin
                mode.um  <= wd_um;
                mode.exl <= wd_exl;
                mode.erl <= wd_erl;
            end
            if (dbg_we)
                mode.dm <= wd_dm;
            if (raise)
                irq <= 1'b1;
            else if (drop)
                irq <= 1'b0;
        end
    end

    // R8: only status writes move the request
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
        !stat_we |=> $stable(irq));

    // R8: dropping the enable lowers the request
    a_r8_irq_drop: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !wd_ie && old_ie) |=> !irq);

    // R7: exception or error level in the write blocks a raise
    a_r7_level_block: assert property (@(posedge clk) disable iff (rst)
        (stat_we && wd_ie && (wd_exl || wd_erl)) |=> $stable(irq));

    // R7: a rising request needs an unmasked pending line
    a_r7_needs_pend: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(stat_we && (|(wd_im & cause_ip))));

    // R6: mode flags follow the status write
    a_r6_flag_follow: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> (mode.um == $past(wd_um)) && (mode.exl == $past(wd_exl)));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [SEL_W-1:0]    wr_sel_i,
    input  logic [XLEN-1:0]     wr_data_i,
    input  logic [SEL_W-1:0]    rd_sel_i,
    output logic [XLEN-1:0]     rd_data_o,
    input  logic [HWP_W-1:0]    hw_pend_i,
    output logic                mode_um_o,
    output logic                mode_exl_o,
    output logic                mode_erl_o,
    output logic                mode_dm_o,
    output logic                irq_o,
    output logic                tlb_flush_o
);

    localparam logic [SEL_W-1:0] FIRST_FREE = SEL_W'(NREG);

    word_t                 regs [NREG];
    logic [NREG*XLEN-1:0]  regs_flat;
    word_t                 cause_view;
    mode_t                 mode;
    logic                  flush_q;

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic we_g;
        assign we_g = wr_en_i && (wr_sel_i == SEL_W'(g));
        sysctl_cell #(
            .KEEP  (keep_mask(g)),
            .WMASK (wr_mask(g))
        ) u_cell (
            .clk (clk),
            .rst (rst),
            .we  (we_g),
            .wd  (wr_data_i),
            .q   (regs[g])
        );
        assign regs_flat[g*XLEN +: XLEN] = regs[g];
    end

    assign cause_view = regs[SEL_CAUSE] | (word_t'(hw_pend_i) << HWP_LO);

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NREG; k++) begin
            if (rd_sel_i == SEL_W'(k))
                rd_data_o = (k == int'(SEL_CAUSE)) ? cause_view : regs[k];
        end
    end

    sysctl_mode_irq u_mode_irq (
        .clk      (clk),
        .rst      (rst),
        .stat_we  (wr_en_i && (wr_sel_i == SEL_STAT)),
        .dbg_we   (wr_en_i && (wr_sel_i == SEL_DBG)),
        .wd_ie    (wr_data_i[ST_IE]),
        .wd_exl   (wr_data_i[ST_EXL]),
        .wd_erl   (wr_data_i[ST_ERL]),
        .wd_um    (wr_data_i[ST_UM]),
        .wd_dm    (wr_data_i[DB_DM]),
        .wd_im    (wr_data_i[IM_LO +: IM_W]),
        .old_ie   (regs[SEL_STAT][ST_IE]),
        .cause_ip (cause_view[IM_LO +: IM_W]),
        .mode     (mode),
        .irq      (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flush_q <= 1'b0;
        else
            flush_q <= wr_en_i && (wr_sel_i == SEL_EHI)
                       && (wr_data_i[ASID_W-1:0] != regs[SEL_EHI][ASID_W-1:0]);
    end

    assign tlb_flush_o = flush_q;
    assign mode_um_o   = mode.um;
    assign mode_exl_o  = mode.exl;
    assign mode_erl_o  = mode.erl;
    assign mode_dm_o   = mode.dm;

    // R5: a flush pulse always follows an entry-high write
    a_r5_flush_origin: assert property (@(posedge clk) disable iff (rst)
        tlb_flush_o |-> $past(wr_en_i && (wr_sel_i == SEL_EHI)));

    // R5: the identifier really changed across the pulse
    a_r5_flush_change: assert property (@(posedge clk) disable iff (rst)
        tlb_flush_o |-> (regs[SEL_EHI][ASID_W-1:0] != $past(regs[SEL_EHI][ASID_W-1:0])));

    // R12: unknown codes leave all state alone
    a_r12_unknown_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wr_sel_i >= FIRST_FREE)) |=>
            ($stable(regs_flat) && $stable(irq_o) && !tlb_flush_o));

endmodule

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/100ps
module sysctl_regbank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en_i;
    logic [4:0]  wr_sel_i;
    logic [31:0] wr_data_i;
    logic [4:0]  rd_sel_i;
    logic [31:0] rd_data_o;
    logic [5:0]  hw_pend_i;
    logic        mode_um_o, mode_exl_o, mode_erl_o, mode_dm_o, irq_o, tlb_flush_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m [32];
    logic e_um, e_exl, e_erl, e_dm, e_irq;

    always #10 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .hw_pend_i(hw_pend_i), .mode_um_o(mode_um_o), .mode_exl_o(mode_exl_o),
        .mode_erl_o(mode_erl_o), .mode_dm_o(mode_dm_o), .irq_o(irq_o),
        .tlb_flush_o(tlb_flush_o)
    );

    function automatic logic [31:0] bw(int s);
        case (s)
            0, 5:             return 32'h0000_000F;
            1, 2:             return 32'h3FFF_FFFF;
            3:                return 32'h007F_FFF0;
            4:                return 32'h01FF_E000;
            6:                return 32'hFFFF_E0FF;
            7:                return 32'hFA78_FF01;
            8:                return 32'h00C0_0300;
            11:               return 32'h40FF_0FF8;
            12:               return 32'h1330_0120;
            14:               return 32'hFFFF_FCF6;
            9, 10, 13, 15, 16: return 32'hFFFF_FFFF;
            default:          return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] bk(int s);
        case (s)
            0:       return 32'h8000_0000;
            3:       return 32'hFF80_0000;
            8:       return 32'hFF3F_FCFF;
            12:      return 32'h8C03_FC1F;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] view(int s);
        if (s == 8) return m[8] | ({26'd0, hw_pend_i} << 10);
        return m[s];
    endfunction

    task automatic check_all(string req);
        for (int s = 0; s < 32; s++) begin
            rd_sel_i = 5'(s);
            #0.2;
            chk(req, rd_data_o, view(s));
        end
        chk({req, " R6 um"},  {31'd0, mode_um_o},  {31'd0, e_um});
        chk({req, " R6 exl"}, {31'd0, mode_exl_o}, {31'd0, e_exl});
        chk({req, " R6 erl"}, {31'd0, mode_erl_o}, {31'd0, e_erl});
        chk({req, " R10 dm"}, {31'd0, mode_dm_o},  {31'd0, e_dm});
        chk({req, " R7/R8 irq"}, {31'd0, irq_o},   {31'd0, e_irq});
    endtask

    task automatic wr(int s, logic [31:0] v, string req);
        logic        fl;
        logic [31:0] cv;
        fl = (s == 6) && (v[7:0] != m[6][7:0]);
        if (s == 7) begin
            cv = view(8);
            if (v[0] && !m[7][0] && !v[1] && !v[2] && !e_dm && (|(v[15:8] & cv[15:8])))
                e_irq = 1'b1;
            else if (!v[0] && m[7][0])
                e_irq = 1'b0;
            e_um = v[4]; e_exl = v[1]; e_erl = v[2];
        end
        if (s == 12) e_dm = v[30];
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 5'(s); wr_data_i = v;
        rd_sel_i = 5'(s);
        #1;
        chk({req, " R13 before edge"}, rd_data_o, view(s));
        if (s < 17) m[s] = (m[s] & bk(s)) | (v & bw(s));
        @(negedge clk);
        wr_en_i = 1'b0;
        chk({req, " R5 flush"}, {31'd0, tlb_flush_o}, {31'd0, fl});
        check_all({req, " R13"});
        @(negedge clk);
        chk({req, " R5 flush end"}, {31'd0, tlb_flush_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h5A5A_5A5A;
        pats[3] = 32'h1234_5678; pats[4] = 32'hCAFE_0F0F; pats[5] = 32'h0000_0000;
        for (int s = 0; s < 32; s++) m[s] = '0;
        e_um = 0; e_exl = 0; e_erl = 0; e_dm = 0; e_irq = 0;
        rst = 1'b1; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; rd_sel_i = 0; hw_pend_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");
        chk("R1 flush", {31'd0, tlb_flush_o}, 32'd0);

        // sweep: R2 R3 R4 R5 R6 R9 R10 R11 R12
        for (int p = 0; p < 6; p++)
            for (int s = 0; s < 32; s++)
                wr(s, pats[p], "sweep R2 R3 R4 R9 R10 R11 R12");

        // R5: same identifier, different upper bits -> no pulse
        wr(6, 32'h0000_2011, "R5 set");
        wr(6, 32'hFFFF_E011, "R5 same asid");
        wr(6, 32'hFFFF_E012, "R5 new asid");

        // R7 / R8 request sequences
        wr(12, 32'h0, "R10 dm off");
        wr(7, 32'h0, "R8 clear");
        wr(8, 32'h0000_0300, "R9 sw pend");
        wr(7, 32'h0000_0101, "R7 raise");
        wr(7, 32'h0000_0301, "R8 hold enabled");
        wr(3, 32'hFFFF_FFFF, "R8 other write");
        wr(7, 32'h0000_0100, "R8 drop");
        wr(7, 32'h0000_0103, "R7 exl blocks");
        wr(7, 32'h0000_0100, "R8 ie off");
        wr(7, 32'h0000_0105, "R7 erl blocks");
        wr(7, 32'h0000_0100, "R8 ie off");
        wr(7, 32'h0000_0401, "R7 mask mismatch");
        wr(7, 32'h0000_0000, "R8 ie off");
        wr(12, 32'h4000_0000, "R10 dm on");
        wr(7, 32'h0000_0111, "R7 dm blocks");
        wr(7, 32'h0000_0000, "R8 ie off");
        wr(12, 32'h0, "R10 dm off");
        wr(8, 32'h0, "R9 sw clear");
        @(negedge clk); hw_pend_i = 6'b000001;
        check_all("R9 hw view");
        wr(7, 32'h0000_0401, "R7 hw raise");
        wr(20, 32'hFFFF_FFFF, "R12 unknown");
        wr(7, 32'h0000_0010, "R8 drop um");
        @(negedge clk); hw_pend_i = 6'b100000;
        check_all("R9 hw top");
        wr(7, 32'h0000_8001, "R7 hw top raise");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule